// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block turns one PWM command into separate enables for the high-side and low-side switches of a synchronous buck stage. Two comparator flags classify the PWM pin as above the high threshold, below the low threshold, or floating in between. A switch is turned on only after gate feedback shows that the opposite switch has turned off and a programmable non-overlap interval has then passed. A PWM level that stays in the middle band for too long parks both switches off.

An optional zero-current (diode-emulation) mode keeps the low-side switch on for a fixed blanking window after it turns on. After that window it releases the switch when the zero-current comparator trips, and the switch stays off until the next PWM high. Each time the driver is enabled, a threshold calibration interval runs with both switches held off. A thermal trip or an active disable also forces both switches off. After any forced-off period, sequencing restarts from the current PWM level through the normal dead-time path. All delays are counted in clock cycles and set by parameters (the defaults assume 100 MHz).

Top module: `buck_gate_sequencer`

## Requirements
- R1: After PWM goes high (`pwm_above_i`=1), `ls_gate_o` drops on the next clock. `hs_gate_o` rises only once `ls_off_i` has been 1 for NOV_CYC consecutive clocks. While `ls_off_i` stays 0, `hs_gate_o` stays 0.
- R2: After PWM goes low (`pwm_below_i`=1, `pwm_above_i`=0), `hs_gate_o` drops on the next clock. `ls_gate_o` rises only once `hs_off_i` has been 1 for NOV_CYC consecutive clocks. While `hs_off_i` stays 0, `ls_gate_o` stays 0.
- R3: With `zc_mode_n_i`=1 (plain mode), `zc_det_i` has no effect: the low-side gate stays on for as long as PWM stays low.
- R4: With `zc_mode_n_i`=0, once `ls_gate_o` rises it stays high for BLANK_CYC+1 clocks whatever `zc_det_i` shows. If `zc_det_i` is 1 at the end of that window, it falls on the next clock.
- R5: After a zero-current release, `ls_gate_o` stays 0 while PWM stays low. The next PWM high starts the high-side sequence.
- R6: When both PWM flags are 0 (mid level), the last valid level is held. On the (HOLDOFF_CYC+1)-th consecutive mid-level clock both gates are turned off, and a shorter mid-level interval has no effect.
- R7: One clock after `drv_dis_n_i` is sampled 0, both gates are 0, and they stay 0 while it stays 0.
- R8: Each 0-to-1 transition of `drv_dis_n_i` (including one seen right after reset) raises `cal_busy_o` on the next clock for exactly CAL_CYC clocks. Both gates stay off during that time, and the normal dead-time path is used afterwards.
- R9: One clock after `therm_trip_i` is sampled 1, both gates are 0. When it clears, sequencing resumes through the dead-time path.
- R10: A PWM reversal during a pending dead-time wait cancels the wait. The new command is then sequenced, and the abandoned switch never turns on.
- R11: `hs_gate_o` and `ls_gate_o` are never 1 in the same cycle.
- R12: During reset, `hs_gate_o`, `ls_gate_o` and `cal_busy_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_above_i | input | 1 | PWM pin above high threshold (takes priority) |
| pwm_below_i | input | 1 | PWM pin below low threshold |
| drv_dis_n_i | input | 1 | Active-low disable; rising edge starts calibration |
| zc_mode_n_i | input | 1 | Active-low zero-current mode select |
| hs_off_i | input | 1 | High-side switch observed off |
| ls_off_i | input | 1 | Low-side switch observed off |
| zc_det_i | input | 1 | Zero-current comparator output |
| therm_trip_i | input | 1 | Thermal-shutdown force-off |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |
| cal_busy_o | output | 1 | Calibration in progress |

## Verification
The hardest situation to reach is a PWM reversal while a dead-time wait is stalled on feedback. With real gates the feedback follows within a cycle, so the window closes almost at once. The bench therefore pins one gate-off flag low so that the sequencer waits in the pending state. It reverses PWM during that wait, then releases the flag, and checks that the abandoned switch never turned on. A behavioural reference model is compared on every clock while mid-level dwell times, zero-current trips and thermal trips are mixed at random.

// File: rtl/buck_seq_pkg.sv
package buck_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_TO_HS,
        PH_HS,
        PH_TO_LS,
        PH_LS,
        PH_ZC_OFF
    } phase_e;

endpackage

// File: rtl/pwm_level_decode.sv
module pwm_level_decode #(
    parameter int unsigned HOLDOFF_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic above_i,
    input  logic below_i,
    output logic want_hi_o,
    output logic tristate_o
);
    localparam int unsigned MW = $clog2(HOLDOFF_CYC + 1);
    localparam logic [MW-1:0] MID_LIMIT = MW'(HOLDOFF_CYC);

    typedef struct packed {
        logic          last_hi;
        logic [MW-1:0] mid_run;
    } dec_t;

    dec_t dec_d, dec_q;
    logic is_mid;
    logic level;

    always_comb begin
        is_mid = !above_i && !below_i;
        if (above_i)      level = 1'b1;
        else if (below_i) level = 1'b0;
        else              level = dec_q.last_hi;

        dec_d         = dec_q;
        dec_d.last_hi = level;
        if (!is_mid)                       dec_d.mid_run = '0;
        else if (dec_q.mid_run != MID_LIMIT) dec_d.mid_run = dec_q.mid_run + 1'b1;

        want_hi_o  = level;
        tristate_o = is_mid && (dec_q.mid_run == MID_LIMIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    // R6: a park request is never raised on the first mid-level sample
    a_r6_no_early_park: assert property (@(posedge clk) disable iff (!rst_n)
        tristate_o |-> $past(!above_i && !below_i));

endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer #(
    parameter int unsigned CAL_CYC = 5500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    output logic hold_o,
    output logic busy_o
);
    localparam int unsigned CW = $clog2(CAL_CYC + 1);
    localparam logic [CW-1:0] CAL_LOAD = CW'(CAL_CYC);

    typedef struct packed {
        logic          en_seen;
        logic [CW-1:0] left;
    } cal_t;

    cal_t cal_d, cal_q;
    logic start;

    always_comb begin
        start         = enable_i && !cal_q.en_seen;
        cal_d         = cal_q;
        cal_d.en_seen = enable_i;
        if (!enable_i)           cal_d.left = '0;
        else if (start)          cal_d.left = CAL_LOAD;
        else if (cal_q.left != 0) cal_d.left = cal_q.left - 1'b1;

        busy_o = (cal_q.left != 0);
        hold_o = start || busy_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cal_q <= '0;
        else        cal_q <= cal_d;
    end

    // R8: an enable edge starts calibration on the next clock
    a_r8_busy_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable_i) |=> busy_o);

    // R8: disabling aborts calibration
    a_r8_abort_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !busy_o);

endmodule

// File: rtl/gate_phase_fsm.sv
module gate_phase_fsm
    import buck_seq_pkg::*;
#(
    parameter int unsigned NOV_CYC   = 3,
    parameter int unsigned BLANK_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_hi_i,
    input  logic force_off_i,
    input  logic zcd_on_i,
    input  logic hs_off_i,
    input  logic ls_off_i,
    input  logic zc_det_i,
    output logic hs_gate_o,
    output logic ls_gate_o
);
    localparam int unsigned CMAX = (NOV_CYC > BLANK_CYC) ? NOV_CYC : BLANK_CYC;
    localparam int unsigned CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] NOV_LAST  = CW'(NOV_CYC - 1);
    localparam logic [CW-1:0] BLANK_END = CW'(BLANK_CYC);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic          hs;
        logic          ls;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (force_off_i) begin
            st_d.ph  = PH_IDLE;
            st_d.cnt = '0;
            st_d.hs  = 1'b0;
            st_d.ls  = 1'b0;
        end else begin
            unique case (st_q.ph)
                PH_IDLE: begin
                    st_d.ph  = want_hi_i ? PH_TO_HS : PH_TO_LS;
                    st_d.cnt = '0;
                end
                PH_TO_HS: begin
                    if (!want_hi_i) begin
                        st_d.ph  = PH_TO_LS;
                        st_d.cnt = '0;
                    end else if (!ls_off_i) begin
                        st_d.cnt = '0;
                    end else if (st_q.cnt == NOV_LAST) begin
                        st_d.ph  = PH_HS;
                        st_d.hs  = 1'b1;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_HS: begin
                    if (!want_hi_i) begin
                        st_d.ph  = PH_TO_LS;
                        st_d.hs  = 1'b0;
                        st_d.cnt = '0;
                    end
                end
                PH_TO_LS: begin
                    if (want_hi_i) begin
                        st_d.ph  = PH_TO_HS;
                        st_d.cnt = '0;
                    end else if (!hs_off_i) begin
                        st_d.cnt = '0;
                    end else if (st_q.cnt == NOV_LAST) begin
                        st_d.ph  = PH_LS;
                        st_d.ls  = 1'b1;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_LS: begin
                    if (want_hi_i) begin
                        st_d.ph  = PH_TO_HS;
                        st_d.ls  = 1'b0;
                        st_d.cnt = '0;
                    end else if (zcd_on_i && (st_q.cnt == BLANK_END) && zc_det_i) begin
                        st_d.ph = PH_ZC_OFF;
                        st_d.ls = 1'b0;
                    end else if (st_q.cnt != BLANK_END) begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_ZC_OFF: begin
                    if (want_hi_i) begin
                        st_d.ph  = PH_TO_HS;
                        st_d.cnt = '0;
                    end
                end
                default: begin
                    st_d.ph  = PH_IDLE;
                    st_d.cnt = '0;
                    st_d.hs  = 1'b0;
                    st_d.ls  = 1'b0;
                end
            endcase
        end
        hs_gate_o = st_q.hs;
        ls_gate_o = st_q.ls;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE, cnt: '0, hs: 1'b0, ls: 1'b0};
        else        st_q <= st_d;
    end

    // R11: the two gates are exclusive
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate_o && ls_gate_o));

    // R1: high side turns on only with low side seen off and PWM high
    a_r1_hs_after_ls_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate_o) |-> $past(ls_off_i) && $past(want_hi_i));

    // R2: low side turns on only with high side seen off and PWM low
    a_r2_ls_after_hs_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate_o) |-> $past(hs_off_i) && !$past(want_hi_i));

    // R4: a fresh low-side pulse survives the next clock unless overridden
    a_r4_blank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate_o) |=> ls_gate_o || $past(force_off_i) || $past(want_hi_i));

    // R7: any force-off clears both gates on the next clock
    a_r7_force_off: assert property (@(posedge clk) disable iff (!rst_n)
        force_off_i |=> !hs_gate_o && !ls_gate_o);

endmodule

// File: rtl/buck_gate_sequencer.sv
module buck_gate_sequencer #(
    parameter int unsigned NOV_CYC     = 3,
    parameter int unsigned BLANK_CYC   = 25,
    parameter int unsigned HOLDOFF_CYC = 25,
    parameter int unsigned CAL_CYC     = 5500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_above_i,
    input  logic pwm_below_i,
    input  logic drv_dis_n_i,
    input  logic zc_mode_n_i,
    input  logic hs_off_i,
    input  logic ls_off_i,
    input  logic zc_det_i,
    input  logic therm_trip_i,
    output logic hs_gate_o,
    output logic ls_gate_o,
    output logic cal_busy_o
);
    logic want_hi;
    logic parked;
    logic cal_hold;
    logic force_off;

    pwm_level_decode #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .above_i    (pwm_above_i),
        .below_i    (pwm_below_i),
        .want_hi_o  (want_hi),
        .tristate_o (parked)
    );

    cal_sequencer #(.CAL_CYC(CAL_CYC)) u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (drv_dis_n_i),
        .hold_o   (cal_hold),
        .busy_o   (cal_busy_o)
    );

    assign force_off = !drv_dis_n_i || therm_trip_i || cal_hold || parked;

    gate_phase_fsm #(.NOV_CYC(NOV_CYC), .BLANK_CYC(BLANK_CYC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .want_hi_i   (want_hi),
        .force_off_i (force_off),
        .zcd_on_i    (!zc_mode_n_i),
        .hs_off_i    (hs_off_i),
        .ls_off_i    (ls_off_i),
        .zc_det_i    (zc_det_i),
        .hs_gate_o   (hs_gate_o),
        .ls_gate_o   (ls_gate_o)
    );

    // R9: thermal trip clears both gates on the next clock
    a_r9_thermal_off: assert property (@(posedge clk) disable iff (!rst_n)
        therm_trip_i |=> !hs_gate_o && !ls_gate_o);

    // R7: port-level disable clears both gates on the next clock
    a_r7_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_dis_n_i |=> !hs_gate_o && !ls_gate_o);

    // R8: no gate is on while calibration runs
    a_r8_quiet_during_cal: assert property (@(posedge clk) disable iff (!rst_n)
        cal_busy_o |-> !hs_gate_o && !ls_gate_o);

endmodule

// File: tb/buck_gate_sequencer_tb_top.sv
`timescale 1ns/1ps
module buck_gate_sequencer_tb_top;
    localparam int NOV   = 3;
    localparam int BLANK = 25;
    localparam int HOLD  = 25;
    localparam int CAL   = 5500;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic above = 1'b0, below = 1'b1, dis_n = 1'b1, zc_n = 1'b1;
    logic zc = 1'b0, trip = 1'b0;
    logic hs_off = 1'b1, ls_off = 1'b1;
    logic hs_stuck = 1'b0, ls_stuck = 1'b0;
    logic hs_gate, ls_gate, busy;

    int n_chk = 0, n_err = 0;

    always #2 clk = ~clk;

    buck_gate_sequencer #(.NOV_CYC(NOV), .BLANK_CYC(BLANK), .HOLDOFF_CYC(HOLD), .CAL_CYC(CAL)) dut_i (
        .clk(clk), .rst_n(rst_n), .pwm_above_i(above), .pwm_below_i(below),
        .drv_dis_n_i(dis_n), .zc_mode_n_i(zc_n), .hs_off_i(hs_off), .ls_off_i(ls_off),
        .zc_det_i(zc), .therm_trip_i(trip), .hs_gate_o(hs_gate), .ls_gate_o(ls_gate),
        .cal_busy_o(busy)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pwm(input int lvl); // 1 high, 0 low, 2 mid
        above = (lvl == 1);
        below = (lvl == 0);
    endtask

    // gate feedback: a gate reads as off one clock after its enable falls
    always @(negedge clk) begin
        hs_off <= !hs_gate && !hs_stuck;
        ls_off <= !ls_gate && !ls_stuck;
    end

    // behavioural reference model
    bit m_valid = 0, m_hs, m_ls, m_last, m_prev_en;
    int m_busy, m_ph, m_cnt, m_mid;
    bit v_mid, v_lvl, v_park, v_start, v_force;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid = 1; m_hs = 0; m_ls = 0; m_last = 0; m_prev_en = 0;
            m_busy = 0; m_ph = 0; m_cnt = 0; m_mid = 0;
        end else begin
            v_mid   = !above && !below;
            v_lvl   = above ? 1'b1 : (below ? 1'b0 : m_last);
            v_park  = v_mid && (m_mid == HOLD);
            v_start = dis_n && !m_prev_en;
            v_force = !dis_n || trip || v_start || (m_busy > 0) || v_park;
            if (v_force) begin
                m_ph = 0; m_cnt = 0; m_hs = 0; m_ls = 0;
            end else begin
                case (m_ph)
                    0: begin m_ph = v_lvl ? 1 : 3; m_cnt = 0; end
                    1: if (!v_lvl) begin m_ph = 3; m_cnt = 0; end
                       else if (!ls_off) m_cnt = 0;
                       else if (m_cnt == NOV - 1) begin m_ph = 2; m_hs = 1; m_cnt = 0; end
                       else m_cnt++;
                    2: if (!v_lvl) begin m_ph = 3; m_hs = 0; m_cnt = 0; end
                    3: if (v_lvl) begin m_ph = 1; m_cnt = 0; end
                       else if (!hs_off) m_cnt = 0;
                       else if (m_cnt == NOV - 1) begin m_ph = 4; m_ls = 1; m_cnt = 0; end
                       else m_cnt++;
                    4: if (v_lvl) begin m_ph = 1; m_ls = 0; m_cnt = 0; end
                       else if (!zc_n && m_cnt == BLANK && zc) begin m_ph = 5; m_ls = 0; end
                       else if (m_cnt < BLANK) m_cnt++;
                    default: if (v_lvl) begin m_ph = 1; m_cnt = 0; end
                endcase
            end
            m_last = v_lvl;
            m_mid  = v_mid ? ((m_mid < HOLD) ? m_mid + 1 : HOLD) : 0;
            if (!dis_n) m_busy = 0;
            else if (v_start) m_busy = CAL;
            else if (m_busy > 0) m_busy--;
            m_prev_en = dis_n;
        end
    end

    always @(negedge clk) begin
        if (m_valid) begin
            chk(!(hs_gate && ls_gate), "R11", "both gates on", 1, 0);
            chk(hs_gate == m_hs, "R1/R2/R10", "model hs_gate", hs_gate, m_hs);
            chk(ls_gate == m_ls, "R2/R4/R5", "model ls_gate", ls_gate, m_ls);
            chk(busy == (m_busy > 0), "R8", "model cal_busy", busy, m_busy > 0);
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int cnt;
        bit seen;
        tick(3);
        // R12 reset state
        chk(!hs_gate && !ls_gate && !busy, "R12", "outputs in reset", {hs_gate, ls_gate, busy}, 0);
        rst_n = 1'b1;
        tick(1);
        chk(busy == 1'b1, "R8", "busy after power-up enable", busy, 1);
        cnt = 0;
        while (busy && cnt < CAL + 10) begin
            chk(!hs_gate && !ls_gate, "R8", "gates during cal", {hs_gate, ls_gate}, 0);
            cnt++; tick(1);
        end
        chk(cnt == CAL, "R8", "busy length", cnt, CAL);
        tick(NOV + 4);
        chk(ls_gate == 1'b1, "R2", "low side after cal", ls_gate, 1);

        // R3 plain mode ignores zero-current flag
        zc = 1'b1; seen = 1'b1;
        repeat (60) begin tick(1); seen &= ls_gate; end
        chk(seen, "R3", "ls held in plain mode", seen, 1);
        zc = 1'b0;

        // R1 high side waits for low-side feedback
        ls_stuck = 1'b1; set_pwm(1);
        tick(1);
        chk(ls_gate == 1'b0, "R1", "ls drops on PWM high", ls_gate, 0);
        seen = 1'b0;
        repeat (40) begin tick(1); seen |= hs_gate; end
        chk(!seen, "R1", "hs while ls not off", seen, 0);
        ls_stuck = 1'b0;
        tick(NOV + 3);
        chk(hs_gate == 1'b1, "R1", "hs after feedback", hs_gate, 1);

        // R2 low side waits for high-side feedback
        hs_stuck = 1'b1; set_pwm(0);
        tick(1);
        chk(hs_gate == 1'b0, "R2", "hs drops on PWM low", hs_gate, 0);
        seen = 1'b0;
        repeat (40) begin tick(1); seen |= ls_gate; end
        chk(!seen, "R2", "ls while hs not off", seen, 0);
        hs_stuck = 1'b0;
        tick(NOV + 3);
        chk(ls_gate == 1'b1, "R2", "ls after feedback", ls_gate, 1);

        // R10 reversal while waiting to turn the high side on
        ls_stuck = 1'b1; set_pwm(1);
        tick(5);
        set_pwm(0);
        tick(2);
        ls_stuck = 1'b0;
        seen = 1'b0;
        repeat (NOV + 4) begin tick(1); seen |= hs_gate; end
        chk(!seen, "R10", "abandoned hs turned on", seen, 0);
        chk(ls_gate == 1'b1, "R10", "ls after reversal", ls_gate, 1);

        // R4 blanking and R5 latch in zero-current mode
        zc_n = 1'b0; zc = 1'b1; set_pwm(1);
        tick(NOV + 4);
        set_pwm(0);
        cnt = 0;
        while (!ls_gate && cnt < 20) begin tick(1); cnt++; end
        cnt = 0;
        while (ls_gate && cnt < BLANK + 20) begin cnt++; tick(1); end
        chk(cnt == BLANK + 1, "R4", "ls pulse length", cnt, BLANK + 1);
        seen = 1'b0;
        repeat (40) begin tick(1); zc = ~zc; seen |= ls_gate; end
        chk(!seen, "R5", "ls after zero-current release", seen, 0);
        set_pwm(1);
        tick(NOV + 4);
        chk(hs_gate == 1'b1, "R5", "hs on next PWM high", hs_gate, 1);
        zc_n = 1'b1; zc = 1'b0;

        // R6 mid-level holdoff
        set_pwm(2);
        tick(HOLD);
        chk(hs_gate == 1'b1, "R6", "hs before holdoff", hs_gate, 1);
        tick(1);
        chk(hs_gate == 1'b0, "R6", "hs after holdoff", hs_gate, 0);
        set_pwm(1);
        tick(NOV + 4);
        chk(hs_gate == 1'b1, "R6", "hs resumes", hs_gate, 1);
        set_pwm(2); seen = 1'b1;
        repeat (10) begin tick(1); seen &= hs_gate; end
        set_pwm(1);
        chk(seen, "R6", "short mid interval", seen, 1);

        // R7 disable, then R8 recalibration
        dis_n = 1'b0;
        tick(1);
        chk(!hs_gate && !ls_gate, "R7", "gates after disable", {hs_gate, ls_gate}, 0);
        seen = 1'b0;
        repeat (20) begin tick(1); above = ~above; below = ~above; seen |= hs_gate | ls_gate; end
        chk(!seen, "R7", "gates while disabled", seen, 0);
        set_pwm(1); dis_n = 1'b1;
        tick(1);
        chk(busy == 1'b1, "R8", "busy after re-enable", busy, 1);
        tick(CAL + NOV + 4);
        chk(hs_gate == 1'b1, "R8", "hs after cal", hs_gate, 1);

        // R9 thermal trip
        trip = 1'b1;
        tick(1);
        chk(!hs_gate && !ls_gate, "R9", "gates on trip", {hs_gate, ls_gate}, 0);
        tick(5); trip = 1'b0;
        tick(NOV + 4);
        chk(hs_gate == 1'b1, "R9", "resume after trip", hs_gate, 1);

        // mixed random traffic against the model
        for (int i = 0; i < 300; i++) begin
            set_pwm($urandom_range(0, 2));
            zc   = $urandom_range(0, 1);
            zc_n = ($urandom_range(0, 3) != 0);
            trip = ($urandom_range(0, 19) == 0);
            tick($urandom_range(1, 40));
        end
        trip = 1'b0;
        tick(10);
        finish_run();
    end
endmodule